// File: doc/BRIEF.md
# Inter-Processor Token Mover

This block copies data tokens, one at a time, from a circular buffer that lives in the memory of one processor into a circular buffer that lives in the memory of another processor. Each buffer is described by a four-word descriptor in memory. The descriptor holds the start address of the storage, the number of slots, the read index (head) and the write index (tail). Software that produces or consumes tokens updates the same descriptors. The engine therefore sees the current occupancy of both buffers every time it polls.

The engine has a sending half and a receiving half. The sending half reads the source descriptor and checks that the source holds a token. It then hands over to the receiving half, which reads the destination descriptor and checks that the destination has room. If both checks pass, the sending half reads the token and passes it across. The receiving half stores the token and advances the destination tail, and the sending half then advances the source head.

Both halves share one memory master port with a request/wait handshake. A small register port configures the engine and reports its state. While enabled, the engine performs single-token transfers back to back. When a transfer cannot proceed, it polls again.

Top module: `tok_xfer_engine`

## Requirements
- R1: After reset the control, status and count registers read as zero and the master port issues no request.
- R2: Register word 0 bit 0 is the enable and reads back as written. Words 1 and 2 hold the source and destination descriptor addresses and read back as written. Word 3 bit 0 reads busy, which is high while a transfer or poll is in progress. Word 4 reads the number of completed transfers.
- R3: A descriptor occupies four consecutive words: start address at +0, slot count at +1, head index at +2, tail index at +3. A token in slot i lives at start+i.
- R4: One transfer copies exactly one token, from source slot head into destination slot tail. It then advances the destination tail by one and the source head by one.
- R5: Within one transfer the memory accesses occur in this order: source descriptor reads, destination descriptor reads, token read, token write, destination tail write, source head write. The two halves never request the port in the same cycle.
- R6: When the source head equals the source tail (empty), no memory write is issued and the count does not change.
- R7: When (destination tail + 1) mod slots equals destination head (full), no memory write is issued, so a buffer of N slots holds at most N-1 tokens.
- R8: While the memory asserts wait, a pending access keeps its request, direction, address and write data unchanged.
- R9: Clearing the enable stops the engine only between transfers. Every transfer already begun completes both pointer updates, after which busy falls and no further request is issued.
- R10: The count register rises by exactly one for each completed transfer.
- R11: A pointer equal to slots-1 advances to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_addr_i | input | SAW | Register word select |
| s_wr_i | input | 1 | Register write strobe |
| s_wdata_i | input | DW | Register write data |
| s_rdata_o | output | DW | Register read data (combinational) |
| m_req_o | output | 1 | Master access request |
| m_we_o | output | 1 | Master access is a write |
| m_addr_o | output | AW | Master word address |
| m_wdata_o | output | DW | Master write data |
| m_rdata_i | input | DW | Master read data, valid when request is high and wait is low |
| m_wait_i | input | 1 | Memory stall; the access completes in a cycle where it is low |

## Verification
A register write that clears the enable can land in the same cycle in which the source head write of a transfer completes. The same write can also land in the middle of a transfer. The bench provokes both by clearing the enable after a random delay during a long run of transfers, with random memory stalls shifting the phase. It judges the outcome by three values that must agree: the count, the source head advance and the destination tail advance. It also checks that no request appears once busy has fallen.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [2:0] {
    SND_IDLE, SND_DESC, SND_WAIT_RX, SND_TOKEN, SND_PASS, SND_HEAD
  } snd_state_e;

  typedef enum logic [2:0] {
    RCV_IDLE, RCV_DESC, RCV_DECIDE, RCV_WAIT_TOK, RCV_TOKEN, RCV_TAIL
  } rcv_state_e;

  // descriptor word offsets
  localparam logic [1:0] DSC_BASE = 2'd0;
  localparam logic [1:0] DSC_SIZE = 2'd1;
  localparam logic [1:0] DSC_HEAD = 2'd2;
  localparam logic [1:0] DSC_TAIL = 2'd3;

  // register word indices
  localparam int unsigned REG_CTRL = 0;
  localparam int unsigned REG_SRC  = 1;
  localparam int unsigned REG_DST  = 2;
  localparam int unsigned REG_STAT = 3;
  localparam int unsigned REG_CNT  = 4;
endpackage

// File: rtl/tx_regs.sv
module tx_regs #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned SAW = 3,
  parameter int unsigned CW  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SAW-1:0] s_addr_i,
  input  logic           s_wr_i,
  input  logic [DW-1:0]  s_wdata_i,
  output logic [DW-1:0]  s_rdata_o,
  input  logic           busy_i,
  input  logic           done_i,
  output logic           en_o,
  output logic [AW-1:0]  src_desc_o,
  output logic [AW-1:0]  dst_desc_o,
  output logic [CW-1:0]  cnt_o
);
  import tx_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o       <= 1'b0;
      src_desc_o <= '0;
      dst_desc_o <= '0;
    end else if (s_wr_i) begin
      case (int'(s_addr_i))
        REG_CTRL: en_o       <= s_wdata_i[0];
        REG_SRC:  src_desc_o <= s_wdata_i[AW-1:0];
        REG_DST:  dst_desc_o <= s_wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (done_i) cnt_o <= cnt_o + 1'b1;
  end

  always_comb begin
    s_rdata_o = '0;
    case (int'(s_addr_i))
      REG_CTRL: s_rdata_o[0]      = en_o;
      REG_SRC:  s_rdata_o[AW-1:0] = src_desc_o;
      REG_DST:  s_rdata_o[AW-1:0] = dst_desc_o;
      REG_STAT: s_rdata_o[0]      = busy_i;
      REG_CNT:  s_rdata_o[CW-1:0] = cnt_o;
      default:  s_rdata_o         = '0;
    endcase
  end
endmodule

// File: rtl/tx_send.sv
module tx_send #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] src_desc_i,
  input  logic [AW-1:0] dst_desc_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          wait_i,
  output logic          rx_start_o,
  output logic [AW-1:0] rx_desc_o,
  input  logic          rx_ok_i,
  input  logic          rx_nack_i,
  output logic          tok_valid_o,
  output logic [DW-1:0] tok_o,
  input  logic          rx_done_i,
  output logic          done_o,
  output logic          busy_o
);
  import tx_pkg::*;

  snd_state_e    state_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] base_q, size_q, head_q, tok_q;
  logic          ack;
  logic [DW-1:0] head_nx, slot_addr;

  assign ack       = req_o && !wait_i;
  assign head_nx   = (head_q + 1'b1 == size_q) ? '0 : head_q + 1'b1;
  assign slot_addr = base_q + head_q;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (state_q)
      SND_DESC: begin
        req_o  = 1'b1;
        addr_o = src_q + {{(AW-2){1'b0}}, idx_q};
      end
      SND_TOKEN: begin
        req_o  = 1'b1;
        addr_o = slot_addr[AW-1:0];
      end
      SND_HEAD: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = src_q + {{(AW-2){1'b0}}, DSC_HEAD};
        wdata_o = head_nx;
      end
      default: ;
    endcase
  end

  // source not empty once tail arrives
  assign rx_start_o  = (state_q == SND_DESC) && ack && (idx_q == DSC_TAIL) && (rdata_i != head_q);
  assign rx_desc_o   = dst_q;
  assign tok_valid_o = (state_q == SND_PASS);
  assign tok_o       = tok_q;
  assign done_o      = (state_q == SND_HEAD) && ack;
  assign busy_o      = (state_q != SND_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SND_IDLE;
      idx_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      base_q  <= '0;
      size_q  <= '0;
      head_q  <= '0;
      tok_q   <= '0;
    end else begin
      case (state_q)
        SND_IDLE: if (en_i) begin
          src_q   <= src_desc_i;
          dst_q   <= dst_desc_i;
          idx_q   <= '0;
          state_q <= SND_DESC;
        end
        SND_DESC: if (ack) begin
          case (idx_q)
            DSC_BASE: base_q <= rdata_i;
            DSC_SIZE: size_q <= rdata_i;
            DSC_HEAD: head_q <= rdata_i;
            default: ;
          endcase
          idx_q <= idx_q + 1'b1;
          if (idx_q == DSC_TAIL) state_q <= rx_start_o ? SND_WAIT_RX : SND_IDLE;
        end
        SND_WAIT_RX: begin
          if (rx_ok_i)        state_q <= SND_TOKEN;
          else if (rx_nack_i) state_q <= SND_IDLE;
        end
        SND_TOKEN: if (ack) begin
          tok_q   <= rdata_i;
          state_q <= SND_PASS;
        end
        SND_PASS: if (rx_done_i) state_q <= SND_HEAD;
        SND_HEAD: if (ack) state_q <= SND_IDLE;
        default: state_q <= SND_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_recv.sv
module tx_recv #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] desc_i,
  output logic          ok_o,
  output logic          nack_o,
  input  logic          tok_valid_i,
  input  logic [DW-1:0] tok_i,
  output logic          done_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  input  logic          wait_i,
  output logic          busy_o
);
  import tx_pkg::*;

  rcv_state_e    state_q;
  logic [1:0]    idx_q;
  logic [AW-1:0] d_q;
  logic [DW-1:0] base_q, size_q, head_q, tail_q, tok_q;
  logic          ack, full;
  logic [DW-1:0] tail_nx, slot_addr;

  assign ack       = req_o && !wait_i;
  assign tail_nx   = (tail_q + 1'b1 == size_q) ? '0 : tail_q + 1'b1;
  assign full      = (tail_nx == head_q);
  assign slot_addr = base_q + tail_q;

  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (state_q)
      RCV_DESC: begin
        req_o  = 1'b1;
        addr_o = d_q + {{(AW-2){1'b0}}, idx_q};
      end
      RCV_TOKEN: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = slot_addr[AW-1:0];
        wdata_o = tok_q;
      end
      RCV_TAIL: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        addr_o  = d_q + {{(AW-2){1'b0}}, DSC_TAIL};
        wdata_o = tail_nx;
      end
      default: ;
    endcase
  end

  assign ok_o   = (state_q == RCV_DECIDE) && !full;
  assign nack_o = (state_q == RCV_DECIDE) && full;
  assign done_o = (state_q == RCV_TAIL) && ack;
  assign busy_o = (state_q != RCV_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RCV_IDLE;
      idx_q   <= '0;
      d_q     <= '0;
      base_q  <= '0;
      size_q  <= '0;
      head_q  <= '0;
      tail_q  <= '0;
      tok_q   <= '0;
    end else begin
      case (state_q)
        RCV_IDLE: if (start_i) begin
          d_q     <= desc_i;
          idx_q   <= '0;
          state_q <= RCV_DESC;
        end
        RCV_DESC: if (ack) begin
          case (idx_q)
            DSC_BASE: base_q <= rdata_i;
            DSC_SIZE: size_q <= rdata_i;
            DSC_HEAD: head_q <= rdata_i;
            default:  tail_q <= rdata_i;
          endcase
          idx_q <= idx_q + 1'b1;
          if (idx_q == DSC_TAIL) state_q <= RCV_DECIDE;
        end
        RCV_DECIDE: state_q <= full ? RCV_IDLE : RCV_WAIT_TOK;
        RCV_WAIT_TOK: if (tok_valid_i) begin
          tok_q   <= tok_i;
          state_q <= RCV_TOKEN;
        end
        RCV_TOKEN: if (ack) state_q <= RCV_TAIL;
        RCV_TAIL:  if (ack) state_q <= RCV_IDLE;
        default: state_q <= RCV_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tok_xfer_engine.sv
module tok_xfer_engine #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 32,
  parameter int unsigned SAW = 3,
  parameter int unsigned CW  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [SAW-1:0] s_addr_i,
  input  logic           s_wr_i,
  input  logic [DW-1:0]  s_wdata_i,
  output logic [DW-1:0]  s_rdata_o,
  output logic           m_req_o,
  output logic           m_we_o,
  output logic [AW-1:0]  m_addr_o,
  output logic [DW-1:0]  m_wdata_o,
  input  logic [DW-1:0]  m_rdata_i,
  input  logic           m_wait_i
);
  logic          en, busy, snd_busy, rcv_busy, xfer_done;
  logic [AW-1:0] src_desc, dst_desc, rx_desc;
  logic [CW-1:0] cnt;
  logic          rx_start, rx_ok, rx_nack, rx_done, tok_valid;
  logic [DW-1:0] tok;
  logic          snd_req, snd_we, rcv_req, rcv_we;
  logic [AW-1:0] snd_addr, rcv_addr;
  logic [DW-1:0] snd_wdata, rcv_wdata;

  assign busy = snd_busy || rcv_busy;

  tx_regs #(.AW(AW), .DW(DW), .SAW(SAW), .CW(CW)) u_regs (
    .clk_i, .rst_ni, .s_addr_i, .s_wr_i, .s_wdata_i, .s_rdata_o,
    .busy_i(busy), .done_i(xfer_done), .en_o(en),
    .src_desc_o(src_desc), .dst_desc_o(dst_desc), .cnt_o(cnt)
  );

  tx_send #(.AW(AW), .DW(DW)) u_send (
    .clk_i, .rst_ni, .en_i(en), .src_desc_i(src_desc), .dst_desc_i(dst_desc),
    .req_o(snd_req), .we_o(snd_we), .addr_o(snd_addr), .wdata_o(snd_wdata),
    .rdata_i(m_rdata_i), .wait_i(m_wait_i),
    .rx_start_o(rx_start), .rx_desc_o(rx_desc), .rx_ok_i(rx_ok), .rx_nack_i(rx_nack),
    .tok_valid_o(tok_valid), .tok_o(tok), .rx_done_i(rx_done),
    .done_o(xfer_done), .busy_o(snd_busy)
  );

  tx_recv #(.AW(AW), .DW(DW)) u_recv (
    .clk_i, .rst_ni, .start_i(rx_start), .desc_i(rx_desc),
    .ok_o(rx_ok), .nack_o(rx_nack), .tok_valid_i(tok_valid), .tok_i(tok),
    .done_o(rx_done),
    .req_o(rcv_req), .we_o(rcv_we), .addr_o(rcv_addr), .wdata_o(rcv_wdata),
    .rdata_i(m_rdata_i), .wait_i(m_wait_i), .busy_o(rcv_busy)
  );

  // halves take turns by protocol; plain OR-mux
  assign m_req_o   = snd_req || rcv_req;
  assign m_we_o    = snd_req ? snd_we    : rcv_we;
  assign m_addr_o  = snd_req ? snd_addr  : rcv_addr;
  assign m_wdata_o = snd_req ? snd_wdata : rcv_wdata;
endmodule

// File: rtl/tx_chk.sv
module tx_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32,
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          m_req_o,
  input logic          m_we_o,
  input logic [AW-1:0] m_addr_o,
  input logic [DW-1:0] m_wdata_o,
  input logic          m_wait_i,
  input logic          snd_req,
  input logic          rcv_req,
  input logic          en,
  input logic          busy,
  input logic [CW-1:0] cnt
);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_req_o && m_wait_i) |=> (m_req_o && $stable(m_we_o) && $stable(m_addr_o) && $stable(m_wdata_o)));

  assert_one_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snd_req && rcv_req));

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));

  assert_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !busy) |=> !m_req_o);

  assert_req_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_req_o |-> busy);
endmodule

bind tok_xfer_engine tx_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_req_o(m_req_o), .m_we_o(m_we_o),
  .m_addr_o(m_addr_o), .m_wdata_o(m_wdata_o), .m_wait_i(m_wait_i),
  .snd_req(snd_req), .rcv_req(rcv_req), .en(en), .busy(busy), .cnt(cnt)
);

// File: tb/tok_xfer_engine_bench.sv
module tok_xfer_engine_bench;
  localparam int AW = 16, DW = 32;
  localparam int SRC_D = 16, DST_D = 32, SRC_B = 64, DST_B = 128;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    s_addr = '0;
  logic          s_wr = 1'b0;
  logic [DW-1:0] s_wdata = '0, s_rdata;
  logic          m_req, m_we, m_wait = 1'b0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic [DW-1:0] mem [0:255];

  int checks = 0, failures = 0, wr_cnt = 0, ord_err = 0, stab_err = 0;
  int last_wr = -1;
  int exp_cnt = 0;
  logic          p_req = 1'b0, p_wait = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_wdata = '0;
  logic [DW-1:0] toks [0:15];

  always #4 clk = ~clk;

  tok_xfer_engine u_tok_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .s_addr_i(s_addr), .s_wr_i(s_wr),
    .s_wdata_i(s_wdata), .s_rdata_o(s_rdata), .m_req_o(m_req), .m_we_o(m_we),
    .m_addr_o(m_addr), .m_wdata_o(m_wdata), .m_rdata_i(m_rdata), .m_wait_i(m_wait)
  );

  assign m_rdata = mem[m_addr[7:0]];

  always @(negedge clk) m_wait <= ($urandom % 4) == 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (p_req && p_wait && (!m_req || m_addr != p_addr || m_we != p_we || m_wdata != p_wdata))
        stab_err++;
      if (m_req && m_we && !m_wait) begin
        mem[m_addr[7:0]] <= m_wdata;
        wr_cnt++;
        if (int'(m_addr) == SRC_D + 2 && last_wr != DST_D + 3) ord_err++;
        if (int'(m_addr) == DST_D + 3 && !(last_wr >= DST_B && last_wr < DST_B + 16)) ord_err++;
        last_wr = int'(m_addr);
      end
      p_req <= m_req; p_wait <= m_wait; p_addr <= m_addr; p_we <= m_we; p_wdata <= m_wdata;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    s_addr = idx[2:0]; s_wdata = d; s_wr = 1'b1;
    @(negedge clk);
    s_wr = 1'b0;
  endtask

  task automatic reg_rd(input int idx, output logic [DW-1:0] d);
    @(negedge clk);
    s_addr = idx[2:0];
    #1 d = s_rdata;
  endtask

  task automatic wait_idle();
    logic [DW-1:0] b;
    for (int i = 0; i < 500; i++) begin
      reg_rd(3, b);
      if (b[0] == 1'b0) break;
    end
  endtask

  function automatic int free_slots(int sz, int occ);
    return sz - 1 - occ;
  endfunction

  task automatic setup(int ss, int sh, int sk, int ds, int dh, int dk);
    mem[SRC_D] = SRC_B; mem[SRC_D+1] = ss; mem[SRC_D+2] = sh; mem[SRC_D+3] = (sh + sk) % ss;
    mem[DST_D] = DST_B; mem[DST_D+1] = ds; mem[DST_D+2] = dh; mem[DST_D+3] = (dh + dk) % ds;
    for (int i = 0; i < 16; i++) begin
      toks[i] = $urandom;
      mem[SRC_B + i] = toks[i];
      mem[DST_B + i] = '0;
    end
    last_wr = -1;
  endtask

  // one enabled run; expected transfers = min(source tokens, destination room)
  task automatic run_round(string name, int ss, int sh, int sk, int ds, int dh, int dk);
    int t, w0;
    logic [DW-1:0] c;
    setup(ss, sh, sk, ds, dh, dk);
    t  = (sk < free_slots(ds, dk)) ? sk : free_slots(ds, dk);
    w0 = wr_cnt;
    reg_wr(0, 1);
    for (int i = 0; i < 3000; i++) begin
      reg_rd(4, c);
      if (int'(c) >= exp_cnt + t) break;
    end
    repeat (60) @(negedge clk);
    reg_wr(0, 0);
    wait_idle();
    exp_cnt += t;
    reg_rd(4, c);
    check(int'(c) == exp_cnt, {name, " R10 count"}, int'(c), exp_cnt);
    check(int'(mem[SRC_D+2]) == (sh + t) % ss, {name, " R4 R11 src head"}, int'(mem[SRC_D+2]), (sh + t) % ss);
    check(int'(mem[DST_D+3]) == (dh + dk + t) % ds, {name, " R4 R11 dst tail"}, int'(mem[DST_D+3]), (dh + dk + t) % ds);
    check(int'(mem[SRC_D+3]) == (sh + sk) % ss && int'(mem[DST_D+2]) == dh, {name, " R3 untouched fields"}, int'(mem[DST_D+2]), dh);
    for (int i = 0; i < t; i++) begin
      int di = (dh + dk + i) % ds, si = (sh + i) % ss;
      check(mem[DST_B + di] == toks[si], {name, " R3 R4 token"}, int'(mem[DST_B + di]), int'(toks[si]));
    end
    check(wr_cnt - w0 == 3 * t, {name, " R6 R7 write count"}, wr_cnt - w0, 3 * t);
  endtask

  initial begin
    logic [DW-1:0] d;
    int c0, h0, t0, dd;
    bit seen;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    reg_rd(0, d); check(d == 0, "R1 ctrl", int'(d), 0);
    reg_rd(3, d); check(d == 0, "R1 busy", int'(d), 0);
    reg_rd(4, d); check(d == 0, "R1 count", int'(d), 0);
    check(m_req == 1'b0, "R1 no request", int'(m_req), 0);
    // R2
    reg_wr(1, SRC_D); reg_wr(2, DST_D);
    reg_rd(1, d); check(int'(d) == SRC_D, "R2 src reg", int'(d), SRC_D);
    reg_rd(2, d); check(int'(d) == DST_D, "R2 dst reg", int'(d), DST_D);
    mem[SRC_D+1] = 4; mem[SRC_D+2] = 0; mem[SRC_D+3] = 0;
    reg_wr(0, 1);
    reg_rd(0, d); check(d[0] == 1'b1, "R2 enable readback", int'(d[0]), 1);
    reg_wr(0, 0); wait_idle();
    // directed corners
    run_round("empty", 5, 2, 0, 5, 0, 0);        // R6
    run_round("full", 5, 0, 3, 4, 1, 3);         // R7
    run_round("wrap", 6, 5, 5, 4, 3, 0);         // R11
    run_round("cap", 8, 0, 7, 8, 0, 0);
    // random rounds
    for (int r = 0; r < 12; r++) begin
      int ss = 3 + $urandom % 14, ds = 3 + $urandom % 14;
      run_round("rand", ss, $urandom % ss, $urandom % ss, ds, $urandom % ds, $urandom % ds);
    end
    check(ord_err == 0, "R5 access order", ord_err, 0);
    check(stab_err == 0, "R8 hold under wait", stab_err, 0);
    // R9: clear enable at random points of a long run
    for (int r = 0; r < 6; r++) begin
      setup(16, r, 15, 16, 0, 0);
      c0 = exp_cnt; h0 = r; t0 = 0;
      reg_wr(0, 1);
      repeat (10 + $urandom % 90) @(negedge clk);
      reg_wr(0, 0);
      wait_idle();
      reg_rd(4, d);
      dd = int'(d) - c0;
      exp_cnt = int'(d);
      check(int'(mem[SRC_D+2]) == (h0 + dd) % 16, "R9 src head at boundary", int'(mem[SRC_D+2]), (h0 + dd) % 16);
      check(int'(mem[DST_D+3]) == (t0 + dd) % 16, "R9 dst tail at boundary", int'(mem[DST_D+3]), (t0 + dd) % 16);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (m_req) seen = 1;
      end
      check(!seen, "R9 quiet after stop", int'(seen), 0);
    end
    check(ord_err == 0, "R5 access order final", ord_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule